// File: doc/BRIEF.md
# Fault Isolation Register Unit

This unit gathers hardware error indications from many independent sources into one sticky error register and turns them into four attention signals that a service processor or firmware can act on. Each error source is a single-cycle pulse. Once captured, a bit stays set until software clears it. A mask register suppresses selected bits. Two action registers give every bit position a two-bit code, and that code decides which attention class the bit raises.

Software reaches the registers through a simple word-wide access port. The port has an address, an enable, a write select, write data and combinational read data. Beside the plain register offsets there are alias offsets. A write to one of these is ANDed or ORed into the error register or the mask, so individual bits can be cleared, injected, masked or unmasked with a single write and no read-modify-write. The port has no back-pressure: every enabled access completes in the cycle it is presented.

Top module: `fault_isolation_unit`

## Requirements
- R1: After reset the mask register reads all ones, the error register and both action registers read zero, and all four attention outputs are low.
- R2: A one-cycle pulse on any `err_in` bit sets that error bit, and the bit stays set over later idle cycles.
- R3: A write to offset 1 ANDs the write data into the error register, so a 0 clears a bit and a 1 keeps it. When a pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A write to offset 0 replaces the error register. A write to offset 2 ORs the write data into it, which injects errors.
- R5: The mask register is read and written at offset 3. A write to offset 4 ANDs data into it, which unmasks bits. A write to offset 5 ORs data into it, which masks bits.
- R6: Action register 0 is read and written at offset 6, and action register 1 at offset 7.
- R7: An error bit whose mask bit is 1 raises no attention output.
- R8: For an error bit that is set and unmasked, the code {action0 bit, action1 bit} selects the class: 00 raises `attn_chkstop`, 01 raises `attn_recov`, 10 raises `attn_host` and 11 raises `attn_unitcs`.
- R9: Each attention output is the OR over all bit positions that qualify for its class. Several classes can be active at the same time.
- R10: A read of an AND or OR alias offset returns the value of the register behind it. Offsets 8 and above read zero, and writes to them change no register.
- R11: The attention outputs are registered. They change one clock after the error, mask or action register that causes the change is updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_in | input | WIDTH | Error pulses, one per source bit |
| acc_en | input | 1 | Access enable |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register offset |
| acc_wdata | input | WIDTH | Write data |
| acc_rdata | output | WIDTH | Read data for an enabled read, zero otherwise |
| attn_chkstop | output | 1 | Checkstop attention (code 00) |
| attn_recov | output | 1 | Recoverable attention (code 01) |
| attn_host | output | 1 | Host attention (code 10) |
| attn_unitcs | output | 1 | Unit checkstop attention (code 11) |

## Verification
All state is reachable through the read port in the same cycle. A corrupted error, mask or action bit therefore shows up on `acc_rdata` as soon as its offset is read, and on the attention outputs one clock after the fault. A wrong class decode for a given bit shows up only when that bit is set and unmasked under the matching code. For that reason the bench sweeps every bit position under every action code and every mask position on its own.

// File: rtl/fir_pkg.sv
package fir_pkg;
  // Register offsets; the decode of the access port depends on these values.
  localparam int OFS_ERR     = 0;
  localparam int OFS_ERR_AND = 1;
  localparam int OFS_ERR_OR  = 2;
  localparam int OFS_MSK     = 3;
  localparam int OFS_MSK_AND = 4;
  localparam int OFS_MSK_OR  = 5;
  localparam int OFS_ACT0    = 6;
  localparam int OFS_ACT1    = 7;
  localparam int NUM_OFS     = 8;
  localparam int NUM_CLASS   = 4;

  // Class index equals the code {action0, action1}.
  typedef enum logic [1:0] {
    CLS_CHKSTOP = 2'd0,
    CLS_RECOV   = 2'd1,
    CLS_HOST    = 2'd2,
    CLS_UNITCS  = 2'd3
  } attn_class_e;
endpackage

// File: rtl/fir_regs.sv
module fir_regs
  import fir_pkg::*;
#(
  parameter int WIDTH  = 64,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  err_pulse,
  output logic [WIDTH-1:0]  err_q,
  output logic [WIDTH-1:0]  mask_q,
  output logic [WIDTH-1:0]  act0_q,
  output logic [WIDTH-1:0]  act1_q
);
  logic [WIDTH-1:0] err_d, mask_d, act0_d, act1_d;

  always_comb begin
    err_d  = err_q;
    mask_d = mask_q;
    act0_d = act0_q;
    act1_d = act1_q;
    if (wr_en) begin
      case (addr)
        ADDR_W'(OFS_ERR):     err_d  = wdata;
        ADDR_W'(OFS_ERR_AND): err_d  = err_q & wdata;
        ADDR_W'(OFS_ERR_OR):  err_d  = err_q | wdata;
        ADDR_W'(OFS_MSK):     mask_d = wdata;
        ADDR_W'(OFS_MSK_AND): mask_d = mask_q & wdata;
        ADDR_W'(OFS_MSK_OR):  mask_d = mask_q | wdata;
        ADDR_W'(OFS_ACT0):    act0_d = wdata;
        ADDR_W'(OFS_ACT1):    act1_d = wdata;
        default: ;
      endcase
    end
    // A new hardware error always wins over a clear in the same cycle.
    err_d = err_d | err_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      mask_q <= '1;
      act0_q <= '0;
      act1_q <= '0;
    end else begin
      err_q  <= err_d;
      mask_q <= mask_d;
      act0_q <= act0_d;
      act1_q <= act1_d;
    end
  end
endmodule

// File: rtl/fir_rdmux.sv
module fir_rdmux
  import fir_pkg::*;
#(
  parameter int WIDTH  = 64,
  parameter int ADDR_W = 4
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  err_q,
  input  logic [WIDTH-1:0]  mask_q,
  input  logic [WIDTH-1:0]  act0_q,
  input  logic [WIDTH-1:0]  act1_q,
  output logic [WIDTH-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        ADDR_W'(OFS_ERR), ADDR_W'(OFS_ERR_AND), ADDR_W'(OFS_ERR_OR): rdata = err_q;
        ADDR_W'(OFS_MSK), ADDR_W'(OFS_MSK_AND), ADDR_W'(OFS_MSK_OR): rdata = mask_q;
        ADDR_W'(OFS_ACT0): rdata = act0_q;
        ADDR_W'(OFS_ACT1): rdata = act1_q;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fir_classify.sv
module fir_classify
  import fir_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WIDTH-1:0]     err_q,
  input  logic [WIDTH-1:0]     mask_q,
  input  logic [WIDTH-1:0]     act0_q,
  input  logic [WIDTH-1:0]     act1_q,
  output logic [NUM_CLASS-1:0] attn_q
);
  logic [WIDTH-1:0] live;
  assign live = err_q & ~mask_q;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    localparam bit SEL0 = ((c / 2) % 2) == 1;
    localparam bit SEL1 = (c % 2) == 1;
    logic [WIDTH-1:0] hit;
    assign hit = live & (SEL0 ? act0_q : ~act0_q) & (SEL1 ? act1_q : ~act1_q);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) attn_q[c] <= 1'b0;
      else        attn_q[c] <= |hit;
    end
  end
endmodule

// File: rtl/fault_isolation_unit.sv
module fault_isolation_unit
  import fir_pkg::*;
#(
  parameter int WIDTH  = 64,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  err_in,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [WIDTH-1:0]  acc_wdata,
  output logic [WIDTH-1:0]  acc_rdata,
  output logic              attn_chkstop,
  output logic              attn_recov,
  output logic              attn_host,
  output logic              attn_unitcs
);
  localparam int MIN_ADDR_W = $clog2(NUM_OFS);

  logic [WIDTH-1:0]     err_q, mask_q, act0_q, act1_q;
  logic [NUM_CLASS-1:0] attn_q;

  initial begin
    if (ADDR_W < MIN_ADDR_W) $error("ADDR_W too small for the register offsets");
  end

  fir_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (acc_en & acc_wr),
    .addr     (acc_addr),
    .wdata    (acc_wdata),
    .err_pulse(err_in),
    .err_q    (err_q),
    .mask_q   (mask_q),
    .act0_q   (act0_q),
    .act1_q   (act1_q)
  );

  fir_rdmux #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rdmux (
    .rd_en (acc_en & ~acc_wr),
    .addr  (acc_addr),
    .err_q (err_q),
    .mask_q(mask_q),
    .act0_q(act0_q),
    .act1_q(act1_q),
    .rdata (acc_rdata)
  );

  fir_classify #(.WIDTH(WIDTH)) u_cls (
    .clk   (clk),
    .rst_n (rst_n),
    .err_q (err_q),
    .mask_q(mask_q),
    .act0_q(act0_q),
    .act1_q(act1_q),
    .attn_q(attn_q)
  );

  assign attn_chkstop = attn_q[CLS_CHKSTOP];
  assign attn_recov   = attn_q[CLS_RECOV];
  assign attn_host    = attn_q[CLS_HOST];
  assign attn_unitcs  = attn_q[CLS_UNITCS];
endmodule

// File: rtl/fir_checker.sv
module fir_checker #(
  parameter int WIDTH  = 64,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WIDTH-1:0]  err_in,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [WIDTH-1:0]  acc_rdata,
  input logic [WIDTH-1:0]  err_q,
  input logic [WIDTH-1:0]  mask_q,
  input logic [WIDTH-1:0]  act0_q,
  input logic [WIDTH-1:0]  act1_q,
  input logic              attn_chkstop,
  input logic              attn_recov,
  input logic              attn_host,
  input logic              attn_unitcs
);
  logic wr_now, unmapped;
  assign wr_now   = acc_en & acc_wr;
  assign unmapped = int'(acc_addr) > 7;

  AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_q & $past(err_in)) == $past(err_in))); // R2

  AST_STICKY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_now) |-> ((err_q & $past(err_q)) == $past(err_q))); // R3

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_q) == {WIDTH{1'b1}}) |->
      !(attn_chkstop | attn_recov | attn_host | attn_unitcs)); // R7

  AST_CHKSTOP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    attn_chkstop == (|$past(err_q & ~mask_q & ~act0_q & ~act1_q))); // R8

  AST_UNITCS_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    attn_unitcs == (|$past(err_q & ~mask_q & act0_q & act1_q))); // R11

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && unmapped) |-> (acc_rdata == '0)); // R10

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_now && unmapped) |->
      ($stable(mask_q) && $stable(act0_q) && $stable(act1_q))); // R10
endmodule

bind fault_isolation_unit fir_checker #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .err_in      (err_in),
  .acc_en      (acc_en),
  .acc_wr      (acc_wr),
  .acc_addr    (acc_addr),
  .acc_rdata   (acc_rdata),
  .err_q       (err_q),
  .mask_q      (mask_q),
  .act0_q      (act0_q),
  .act1_q      (act1_q),
  .attn_chkstop(attn_chkstop),
  .attn_recov  (attn_recov),
  .attn_host   (attn_host),
  .attn_unitcs (attn_unitcs)
);

// File: tb/tb_fault_isolation_unit.sv
`timescale 1ns/1ps
module tb_fault_isolation_unit;
  localparam int W  = 64;
  localparam int AW = 4;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [W-1:0]  err_in;
  logic          acc_en, acc_wr;
  logic [AW-1:0] acc_addr;
  logic [W-1:0]  acc_wdata, acc_rdata;
  logic          attn_chkstop, attn_recov, attn_host, attn_unitcs;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  fault_isolation_unit #(.WIDTH(W), .ADDR_W(AW)) dut (.*);

  function automatic logic [W-1:0] attn_vec();
    return {60'd0, attn_unitcs, attn_host, attn_recov, attn_chkstop};
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [W-1:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_addr = AW'(a); acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(int a, output logic [W-1:0] d);
    acc_en = 1; acc_wr = 0; acc_addr = AW'(a);
    #1 d = acc_rdata;
    acc_en = 0;
  endtask

  task automatic rdchk(string req, int a, logic [W-1:0] exp);
    logic [W-1:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; err_in = '0; acc_en = 0; acc_wr = 0; acc_addr = '0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rdchk("R1 err", 0, '0);
    rdchk("R1 mask", 3, ONES);
    rdchk("R1 act0", 6, '0);
    rdchk("R1 act1", 7, '0);
    chk("R1 attn", attn_vec(), '0);
    // R10 alias reads
    rdchk("R10 alias1", 1, '0);
    rdchk("R10 alias2", 2, '0);
    rdchk("R10 alias4", 4, ONES);
    rdchk("R10 alias5", 5, ONES);

    // R2 sticky capture
    @(negedge clk); err_in = 64'h8000_0000_0000_0001;
    @(negedge clk); err_in = '0;
    rdchk("R2 capture", 0, 64'h8000_0000_0000_0001);
    repeat (3) @(negedge clk);
    rdchk("R2 held", 0, 64'h8000_0000_0000_0001);

    // R3 AND clear and set-wins
    wr(1, ~64'h1);
    rdchk("R3 and clear", 0, 64'h8000_0000_0000_0000);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_addr = AW'(1); acc_wdata = '0; err_in = 64'h20;
    @(negedge clk);
    acc_en = 0; acc_wr = 0; err_in = '0;
    rdchk("R3 set wins", 0, 64'h20);

    // R4 direct write and OR injection
    wr(2, 64'hF0);
    rdchk("R4 or inject", 0, 64'hF0);
    wr(0, 64'h3);
    rdchk("R4 direct", 0, 64'h3);

    // R5 mask access
    wr(3, 64'h1234_5678_9ABC_DEF0);
    rdchk("R5 mask write", 3, 64'h1234_5678_9ABC_DEF0);
    wr(4, 64'hFF00_FF00_FF00_FF00);
    rdchk("R5 mask and", 3, 64'h1200_5600_9A00_DE00);
    wr(5, 64'h1);
    rdchk("R5 mask or", 3, 64'h1200_5600_9A00_DE01);

    // R6 action registers
    wr(6, 64'hA5A5_0000_FFFF_0001);
    wr(7, 64'h0F0F_1111_2222_3333);
    rdchk("R6 act0", 6, 64'hA5A5_0000_FFFF_0001);
    rdchk("R6 act1", 7, 64'h0F0F_1111_2222_3333);

    // R10 unmapped writes and reads
    for (int a = 8; a < 16; a++) wr(a, ONES);
    rdchk("R10 unmapped err", 0, 64'h3);
    rdchk("R10 unmapped mask", 3, 64'h1200_5600_9A00_DE01);
    rdchk("R10 unmapped act0", 6, 64'hA5A5_0000_FFFF_0001);
    rdchk("R10 unmapped act1", 7, 64'h0F0F_1111_2222_3333);
    rdchk("R10 unmapped read 9", 9, '0);
    rdchk("R10 unmapped read 15", 15, '0);

    // R7 mask sweep: all errors set, codes 00, one bit unmasked at a time
    wr(6, '0); wr(7, '0); wr(3, ONES); wr(2, ONES);
    @(negedge clk);
    chk("R7 all masked", attn_vec(), '0);
    for (int b = 0; b < W; b++) begin
      wr(3, ~(64'h1 << b));
      @(negedge clk);
      chk($sformatf("R7 unmask bit %0d", b), attn_vec(), 64'h1);
      wr(3, ONES);
      @(negedge clk);
      chk($sformatf("R7 remask bit %0d", b), attn_vec(), '0);
    end

    // R8 class sweep over every bit and code
    wr(0, '0); wr(3, '0);
    for (int code = 0; code < 4; code++) begin
      wr(6, code[1] ? ONES : '0);
      wr(7, code[0] ? ONES : '0);
      for (int b = 0; b < W; b++) begin
        wr(0, 64'h1 << b);
        @(negedge clk);
        chk($sformatf("R8 code %0d bit %0d", code, b), attn_vec(), 64'h1 << code);
      end
      wr(0, '0);
      @(negedge clk);
    end

    // R11 one-cycle latency (actions all ones, code 11)
    wr(2, 64'h80);
    chk("R11 not yet set", attn_vec(), '0);
    @(negedge clk);
    chk("R11 set", attn_vec(), 64'h8);
    wr(1, '0);
    chk("R11 not yet clear", attn_vec(), 64'h8);
    @(negedge clk);
    chk("R11 clear", attn_vec(), '0);

    // R9 mixed classes at once
    wr(6, 64'hC); wr(7, 64'hA);
    wr(0, 64'hF);
    @(negedge clk);
    chk("R9 four classes", attn_vec(), 64'hF);
    wr(0, 64'h5);
    @(negedge clk);
    chk("R9 chk+host", attn_vec(), 64'h5);
    @(negedge clk); err_in = 64'h2;
    @(negedge clk); err_in = '0;
    @(negedge clk);
    chk("R9 pulse adds recov", attn_vec(), 64'h7);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule